// File: doc/BRIEF.md
# Transactional Footprint Conflict Tracker

This block follows the memory footprint of one core's hardware transaction and decides whether the transaction commits or aborts. The local core opens a transaction, issues transactional loads and stores with addresses, and finally requests a commit. Each load records its cache line in a read set. Each store records its line in a write set and holds the store data in a speculative buffer. A snoop port presents read and write addresses that other cores issue, and each accepted snoop is checked against the two sets.

A remote read conflicts only with the write set. A remote write conflicts with either set. Lines are 64 bytes, so any two addresses that share bits [31:6] match, and false matches on neighbouring bytes are accepted. A load or store that needs a new entry when its set is already full also aborts the transaction. On abort the block drops every buffered store and gives a one-cycle abort pulse with a cause code. On commit it holds a lock that refuses snoops and drains the buffered stores to a memory write port, one word per cycle, as a single uninterrupted burst. While the transaction runs, a load of a word that the transaction has already stored is answered from the buffer.

Top module: `tx_conflict_tracker`

## Requirements
- R1: After reset the block is idle: tx_active, abort_pulse, mem_lock, mem_wr_valid and commit_done are 0 and snp_ready is 1.
- R2: core_begin in the idle state makes tx_active 1 from the next cycle. A second load or store to a line that is already tracked allocates no new entry.
- R3: An accepted remote read (snp_write=0) whose line matches a write-set line aborts: abort_pulse is 1 in the cycle after the snoop, with abort_cause 0.
- R4: A remote read whose line is only in the read set is not a conflict, and tx_active stays 1.
- R5: An accepted remote write (snp_write=1) whose line matches a read-set or write-set line aborts with abort_cause 1, one cycle after the snoop.
- R6: A line is address bits [31:6]. Addresses that differ only in bits [5:0] match, and addresses in different lines do not.
- R7: A load or store to a new line when its set already holds 8 lines aborts with abort_cause 2. An access to a tracked line never overflows.
- R8: After an abort no buffered store ever reaches mem_wr_valid, and a later transaction that commits with no stores writes nothing.
- R9: After core_commit the block holds mem_lock=1 and snp_ready=0 and drains one word per cycle. Lines go in the order they were first stored, and words within a line go in ascending address order. A later store to the same word replaces the earlier data. Snoops offered while locked have no effect.
- R10: During a transaction, a load of a word already stored gives core_fwd_hit=1 and the latest stored data in the same cycle. A load of an unstored word gives core_fwd_hit=0.
- R11: A snoop in the same cycle as a local access is checked against the sets as they were before that access, so a store and a remote write to the same new line in one cycle do not conflict.
- R12: abort_pulse lasts exactly one cycle and tx_active is 0 afterwards. commit_done is a one-cycle pulse after the last drained word, and mem_lock is 0 in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_begin | input | 1 | Open a transaction (idle only) |
| core_commit | input | 1 | Request commit of the running transaction |
| core_req_valid | input | 1 | Transactional access present |
| core_req_write | input | 1 | 1 = store, 0 = load |
| core_req_addr | input | 32 | Access byte address (word aligned) |
| core_req_wdata | input | 32 | Store data |
| core_fwd_hit | output | 1 | Load answered from the speculative buffer |
| core_fwd_data | output | 32 | Forwarded load data |
| snp_valid | input | 1 | Remote access present |
| snp_write | input | 1 | 1 = remote write, 0 = remote read |
| snp_addr | input | 32 | Remote access byte address |
| snp_ready | output | 1 | Snoops accepted (low while committing) |
| mem_wr_valid | output | 1 | Committed store word valid |
| mem_wr_addr | output | 32 | Committed store address |
| mem_wr_data | output | 32 | Committed store data |
| mem_lock | output | 1 | Atomic commit burst in progress |
| tx_active | output | 1 | Transaction running |
| abort_pulse | output | 1 | One-cycle abort indication |
| abort_cause | output | 2 | 0 read conflict, 1 write conflict, 2 capacity |
| commit_done | output | 1 | One-cycle commit completion |

## Verification
The bench builds the block with its default parameters: 32-bit addresses and data, 64-byte lines and 8 entries in each set. With these values both sets fill after eight distinct lines, so the ninth-line overflow and the harmless re-access of a full set can be reached within a few cycles. The 16-word lines also allow same-line, different-byte aliasing to be shown with small address offsets. Drain ordering is shown with one line stored out of address order, so that the allocation order and the address order of the lines differ.

// File: rtl/tx_pkg.sv
`timescale 1ns/1ps
package tx_pkg;
  typedef enum logic [1:0] {
    TX_IDLE   = 2'd0,
    TX_ACTIVE = 2'd1,
    TX_COMMIT = 2'd2,
    TX_ABORT  = 2'd3
  } tx_state_e;

  localparam logic [1:0] CAUSE_RD  = 2'd0;
  localparam logic [1:0] CAUSE_WR  = 2'd1;
  localparam logic [1:0] CAUSE_CAP = 2'd2;
endpackage

// File: rtl/tx_line_cam.sv
`timescale 1ns/1ps
module tx_line_cam #(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 26,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             ins_en,
  input  logic [TAG_W-1:0] loc_tag,
  output logic             loc_hit,
  output logic [IDX_W-1:0] slot_idx,
  output logic             ovf,
  input  logic [TAG_W-1:0] snp_tag,
  output logic             snp_hit,
  input  logic [IDX_W-1:0] peek_idx,
  output logic [TAG_W-1:0] peek_tag
);
  logic [ENTRIES-1:0] vld;
  logic [TAG_W-1:0]   tags [ENTRIES];
  logic [ENTRIES-1:0] loc_m;
  logic [ENTRIES-1:0] snp_m;
  logic [IDX_W-1:0]   loc_idx;
  logic [IDX_W-1:0]   free_idx;
  logic               full;
  logic               alloc;

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_cmp
      assign loc_m[g] = vld[g] && (tags[g] == loc_tag);
      assign snp_m[g] = vld[g] && (tags[g] == snp_tag);
    end
  endgenerate

  always_comb begin
    loc_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (loc_m[i]) loc_idx = IDX_W'(i);
  end

  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!vld[i]) free_idx = IDX_W'(i);
  end

  assign full     = &vld;
  assign loc_hit  = |loc_m;
  assign snp_hit  = |snp_m;
  assign ovf      = ins_en && !loc_hit && full;
  assign alloc    = ins_en && !loc_hit && !full && !clr;
  assign slot_idx = loc_hit ? loc_idx : free_idx;
  assign peek_tag = tags[peek_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     vld <= '0;
    else if (clr)   vld <= '0;
    else if (alloc) vld[free_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (alloc) tags[free_idx] <= loc_tag;
  end
endmodule

// File: rtl/tx_store_buf.sv
`timescale 1ns/1ps
module tx_store_buf #(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = 3,
  parameter int WSEL_W  = 4,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WSEL_W-1:0] wr_word,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  fwd_idx,
  input  logic [WSEL_W-1:0] fwd_word,
  output logic              fwd_vld,
  output logic [DATA_W-1:0] fwd_data,
  input  logic              drain_en,
  output logic              pend,
  output logic [IDX_W-1:0]  pick_idx,
  output logic [WSEL_W-1:0] pick_word,
  output logic [DATA_W-1:0] pick_data
);
  localparam int WORDS  = 1 << WSEL_W;
  localparam int SLOTS  = ENTRIES * WORDS;
  localparam int SLOT_W = IDX_W + WSEL_W;

  logic [SLOTS-1:0]  live;
  logic [DATA_W-1:0] mem [SLOTS];
  logic [SLOT_W-1:0] pick;
  logic [SLOT_W-1:0] ws;
  logic [SLOT_W-1:0] fs;

  function automatic logic [SLOT_W-1:0] slot_of(input logic [IDX_W-1:0] e,
                                                input logic [WSEL_W-1:0] w);
    return {e, w};
  endfunction

  assign ws = slot_of(wr_idx, wr_word);
  assign fs = slot_of(fwd_idx, fwd_word);

  always_comb begin
    pick = '0;
    for (int i = SLOTS - 1; i >= 0; i--)
      if (live[i]) pick = SLOT_W'(i);
  end

  assign pend      = |live;
  assign pick_idx  = pick[SLOT_W-1:WSEL_W];
  assign pick_word = pick[WSEL_W-1:0];
  assign pick_data = mem[pick];
  assign fwd_vld   = live[fs];
  assign fwd_data  = mem[fs];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live <= '0;
    end else if (clr) begin
      live <= '0;
    end else begin
      if (drain_en && pend) live[pick] <= 1'b0;
      if (wr_en)            live[ws]   <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !clr) mem[ws] <= wr_data;
  end
endmodule

// File: rtl/tx_conflict_tracker.sv
`timescale 1ns/1ps
module tx_conflict_tracker
  import tx_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_LOG2  = 6,
  parameter int RD_ENTRIES = 8,
  parameter int WR_ENTRIES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_begin,
  input  logic              core_commit,
  input  logic              core_req_valid,
  input  logic              core_req_write,
  input  logic [ADDR_W-1:0] core_req_addr,
  input  logic [DATA_W-1:0] core_req_wdata,
  output logic              core_fwd_hit,
  output logic [DATA_W-1:0] core_fwd_data,
  input  logic              snp_valid,
  input  logic              snp_write,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_ready,
  output logic              mem_wr_valid,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  output logic              mem_lock,
  output logic              tx_active,
  output logic              abort_pulse,
  output logic [1:0]        abort_cause,
  output logic              commit_done
);
  localparam int BOFF   = $clog2(DATA_W / 8);
  localparam int WSEL_W = LINE_LOG2 - BOFF;
  localparam int TAG_W  = ADDR_W - LINE_LOG2;
  localparam int RIDX_W = $clog2(RD_ENTRIES);
  localparam int WIDX_W = $clog2(WR_ENTRIES);

  function automatic logic [ADDR_W-1:0] addr_of(input logic [TAG_W-1:0] tag,
                                                input logic [WSEL_W-1:0] w);
    return {tag, w, {BOFF{1'b0}}};
  endfunction

  function automatic logic [1:0] cause_of(input logic rd_hit, input logic wr_hit);
    if (rd_hit)      return CAUSE_RD;
    else if (wr_hit) return CAUSE_WR;
    else             return CAUSE_CAP;
  endfunction

  tx_state_e state_q;
  tx_state_e state_d;
  logic [1:0] cause_q;

  logic [TAG_W-1:0]  loc_tag;
  logic [TAG_W-1:0]  snp_tag;
  logic [WSEL_W-1:0] loc_word;
  logic              lsb_unused;

  assign loc_tag    = core_req_addr[ADDR_W-1:LINE_LOG2];
  assign snp_tag    = snp_addr[ADDR_W-1:LINE_LOG2];
  assign loc_word   = core_req_addr[LINE_LOG2-1:BOFF];
  assign lsb_unused = ^{core_req_addr[BOFF-1:0], snp_addr[LINE_LOG2-1:0]};

  logic in_active;
  logic ld_go;
  logic st_go;
  logic snp_take;
  logic begin_go;
  logic set_clr;
  logic go_abort;

  logic evt_rd_conflict;
  logic evt_wr_conflict;
  logic evt_overflow;
  logic evt_commit_start;
  logic drain_fire;

  logic              rd_loc_hit, rd_snp_hit, rd_ovf;
  logic [RIDX_W-1:0] rd_slot;
  logic [TAG_W-1:0]  rd_peek_tag;
  logic              wr_loc_hit, wr_snp_hit, wr_ovf;
  logic [WIDX_W-1:0] wr_slot;
  logic [TAG_W-1:0]  wr_peek_tag;

  logic              sb_fwd_vld;
  logic [DATA_W-1:0] sb_fwd_data;
  logic              sb_pend;
  logic [WIDX_W-1:0] sb_pick_idx;
  logic [WSEL_W-1:0] sb_pick_word;
  logic [DATA_W-1:0] sb_pick_data;

  assign in_active = (state_q == TX_ACTIVE);
  assign ld_go     = in_active && core_req_valid && !core_req_write;
  assign st_go     = in_active && core_req_valid && core_req_write;
  assign snp_take  = in_active && snp_valid;
  assign begin_go  = (state_q == TX_IDLE) && core_begin;

  assign evt_rd_conflict  = snp_take && !snp_write && wr_snp_hit;
  assign evt_wr_conflict  = snp_take && snp_write && (wr_snp_hit || rd_snp_hit);
  assign evt_overflow     = rd_ovf || wr_ovf;
  assign go_abort         = evt_rd_conflict || evt_wr_conflict || evt_overflow;
  assign evt_commit_start = in_active && core_commit && !go_abort;
  assign set_clr          = begin_go || go_abort;
  assign drain_fire       = (state_q == TX_COMMIT) && sb_pend;

  tx_line_cam #(
    .ENTRIES(RD_ENTRIES), .TAG_W(TAG_W), .IDX_W(RIDX_W)
  ) u_rd_set (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (set_clr),
    .ins_en   (ld_go),
    .loc_tag  (loc_tag),
    .loc_hit  (rd_loc_hit),
    .slot_idx (rd_slot),
    .ovf      (rd_ovf),
    .snp_tag  (snp_tag),
    .snp_hit  (rd_snp_hit),
    .peek_idx (rd_slot),
    .peek_tag (rd_peek_tag)
  );

  logic rd_aux_unused;
  assign rd_aux_unused = ^{rd_loc_hit, rd_peek_tag};

  tx_line_cam #(
    .ENTRIES(WR_ENTRIES), .TAG_W(TAG_W), .IDX_W(WIDX_W)
  ) u_wr_set (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (set_clr),
    .ins_en   (st_go),
    .loc_tag  (loc_tag),
    .loc_hit  (wr_loc_hit),
    .slot_idx (wr_slot),
    .ovf      (wr_ovf),
    .snp_tag  (snp_tag),
    .snp_hit  (wr_snp_hit),
    .peek_idx (sb_pick_idx),
    .peek_tag (wr_peek_tag)
  );

  tx_store_buf #(
    .ENTRIES(WR_ENTRIES), .IDX_W(WIDX_W), .WSEL_W(WSEL_W), .DATA_W(DATA_W)
  ) u_sbuf (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (set_clr),
    .wr_en     (st_go && !wr_ovf),
    .wr_idx    (wr_slot),
    .wr_word   (loc_word),
    .wr_data   (core_req_wdata),
    .fwd_idx   (wr_slot),
    .fwd_word  (loc_word),
    .fwd_vld   (sb_fwd_vld),
    .fwd_data  (sb_fwd_data),
    .drain_en  (drain_fire),
    .pend      (sb_pend),
    .pick_idx  (sb_pick_idx),
    .pick_word (sb_pick_word),
    .pick_data (sb_pick_data)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      TX_IDLE:   if (begin_go) state_d = TX_ACTIVE;
      TX_ACTIVE: begin
        if (go_abort)              state_d = TX_ABORT;
        else if (evt_commit_start) state_d = TX_COMMIT;
      end
      TX_COMMIT: if (!sb_pend) state_d = TX_IDLE;
      TX_ABORT:  state_d = TX_IDLE;
      default:   state_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      cause_q <= CAUSE_RD;
    end else begin
      state_q <= state_d;
      if (go_abort) cause_q <= cause_of(evt_rd_conflict, evt_wr_conflict);
    end
  end

  assign core_fwd_hit  = ld_go && wr_loc_hit && sb_fwd_vld;
  assign core_fwd_data = sb_fwd_data;
  assign mem_lock      = (state_q == TX_COMMIT);
  assign snp_ready     = !mem_lock;
  assign mem_wr_valid  = drain_fire;
  assign mem_wr_addr   = addr_of(wr_peek_tag, sb_pick_word);
  assign mem_wr_data   = sb_pick_data;
  assign tx_active     = in_active;
  assign abort_pulse   = (state_q == TX_ABORT);
  assign abort_cause   = cause_q;
  assign commit_done   = mem_lock && !sb_pend;
endmodule

// File: rtl/tx_conflict_tracker_chk.sv
`timescale 1ns/1ps
module tx_conflict_tracker_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       snp_ready,
  input logic       mem_lock,
  input logic       mem_wr_valid,
  input logic       abort_pulse,
  input logic [1:0] abort_cause,
  input logic       tx_active,
  input logic       commit_done,
  input logic       evt_rd_conflict,
  input logic       evt_wr_conflict,
  input logic       evt_overflow,
  input logic       evt_commit_start
);
  AST_LOCK_BLOCKS_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_lock |-> !snp_ready); // R9

  AST_WRITE_ONLY_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |-> mem_lock); // R9

  AST_COMMIT_TAKES_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    evt_commit_start |=> mem_lock); // R9

  AST_RD_CONFLICT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rd_conflict |=> (abort_pulse && abort_cause == 2'd0)); // R3

  AST_WR_CONFLICT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_wr_conflict |=> (abort_pulse && abort_cause == 2'd1)); // R5

  AST_CAPACITY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_overflow && !evt_rd_conflict && !evt_wr_conflict) |=>
      (abort_pulse && abort_cause == 2'd2)); // R7

  AST_ABORT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |=> (!abort_pulse && !tx_active)); // R12

  AST_ABORT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |=> !mem_wr_valid); // R8

  AST_DONE_FREES_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    commit_done |=> !mem_lock); // R12
endmodule

bind tx_conflict_tracker tx_conflict_tracker_chk u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .snp_ready        (snp_ready),
  .mem_lock         (mem_lock),
  .mem_wr_valid     (mem_wr_valid),
  .abort_pulse      (abort_pulse),
  .abort_cause      (abort_cause),
  .tx_active        (tx_active),
  .commit_done      (commit_done),
  .evt_rd_conflict  (evt_rd_conflict),
  .evt_wr_conflict  (evt_wr_conflict),
  .evt_overflow     (evt_overflow),
  .evt_commit_start (evt_commit_start)
);

// File: tb/tx_conflict_tracker_bench.sv
`timescale 1ns/1ps
module tx_conflict_tracker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        core_begin = 1'b0, core_commit = 1'b0;
  logic        core_req_valid = 1'b0, core_req_write = 1'b0;
  logic [31:0] core_req_addr = '0, core_req_wdata = '0;
  logic        core_fwd_hit;
  logic [31:0] core_fwd_data;
  logic        snp_valid = 1'b0, snp_write = 1'b0;
  logic [31:0] snp_addr = '0;
  logic        snp_ready, mem_wr_valid, mem_lock, tx_active, abort_pulse, commit_done;
  logic [31:0] mem_wr_addr, mem_wr_data;
  logic [1:0]  abort_cause;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] got_a [16];
  logic [31:0] got_d [16];
  int got_n;

  always #2.5 clk = ~clk;

  tx_conflict_tracker u_tx_conflict_tracker (
    .clk(clk), .rst_n(rst_n),
    .core_begin(core_begin), .core_commit(core_commit),
    .core_req_valid(core_req_valid), .core_req_write(core_req_write),
    .core_req_addr(core_req_addr), .core_req_wdata(core_req_wdata),
    .core_fwd_hit(core_fwd_hit), .core_fwd_data(core_fwd_data),
    .snp_valid(snp_valid), .snp_write(snp_write), .snp_addr(snp_addr),
    .snp_ready(snp_ready),
    .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .mem_lock(mem_lock), .tx_active(tx_active),
    .abort_pulse(abort_pulse), .abort_cause(abort_cause), .commit_done(commit_done)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_begin();
    core_begin = 1'b1;
    @(negedge clk);
    core_begin = 1'b0;
    check("R2", "tx_active after begin", tx_active, 1);
  endtask

  task automatic access(input logic wr, input logic [31:0] a, input logic [31:0] d);
    core_req_valid = 1'b1; core_req_write = wr; core_req_addr = a; core_req_wdata = d;
    @(negedge clk);
    core_req_valid = 1'b0; core_req_write = 1'b0;
  endtask

  task automatic snoop(input logic wr, input logic [31:0] a);
    snp_valid = 1'b1; snp_write = wr; snp_addr = a;
    @(negedge clk);
    snp_valid = 1'b0; snp_write = 1'b0;
  endtask

  task automatic expect_abort(input string req, input logic [1:0] cause);
    check(req, "abort_pulse", abort_pulse, 1);
    check(req, "abort_cause", abort_cause, cause);
    check("R8", "no write on abort", mem_wr_valid, 0);
    @(negedge clk);
    check("R12", "abort pulse one cycle", abort_pulse, 0);
    check("R12", "tx_active after abort", tx_active, 0);
  endtask

  task automatic expect_running(input string req);
    check(req, "no abort", abort_pulse, 0);
    check(req, "still active", tx_active, 1);
  endtask

  task automatic load_probe(input logic [31:0] a, input logic exp_hit,
                            input logic [31:0] exp_d);
    core_req_valid = 1'b1; core_req_write = 1'b0; core_req_addr = a;
    #1;
    check("R10", "fwd hit", core_fwd_hit, exp_hit);
    if (exp_hit) check("R10", "fwd data", core_fwd_data, exp_d);
    @(negedge clk);
    core_req_valid = 1'b0;
  endtask

  task automatic run_commit(input logic snoop_on, input logic [31:0] saddr);
    got_n = 0;
    core_commit = 1'b1;
    @(negedge clk);
    core_commit = 1'b0;
    snp_valid = snoop_on; snp_write = 1'b1; snp_addr = saddr;
    for (int k = 0; k < 40; k++) begin
      if (commit_done) break;
      check("R9", "lock during drain", mem_lock, 1);
      check("R9", "snp_ready low during drain", snp_ready, 0);
      if (mem_wr_valid && got_n < 16) begin
        got_a[got_n] = mem_wr_addr;
        got_d[got_n] = mem_wr_data;
        got_n++;
      end
      @(negedge clk);
    end
    snp_valid = 1'b0;
    check("R12", "commit_done", commit_done, 1);
    check("R9", "no abort during commit", abort_pulse, 0);
    @(negedge clk);
    check("R12", "lock released", mem_lock, 0);
    check("R12", "idle after commit", tx_active, 0);
    check("R12", "commit_done one cycle", commit_done, 0);
  endtask

  task automatic t_reset();
    check("R1", "tx_active", tx_active, 0);
    check("R1", "abort_pulse", abort_pulse, 0);
    check("R1", "mem_lock", mem_lock, 0);
    check("R1", "mem_wr_valid", mem_wr_valid, 0);
    check("R1", "commit_done", commit_done, 0);
    check("R1", "snp_ready", snp_ready, 1);
  endtask

  task automatic t_read_set();
    do_begin();
    access(1'b0, 32'h0000_1000, '0);
    snoop(1'b0, 32'h0000_1000);
    expect_running("R4");
    @(negedge clk);
    expect_running("R4");
    snoop(1'b1, 32'h0000_1024);
    expect_abort("R5 R6", 2'd1);
  endtask

  task automatic t_write_set_read_conflict();
    do_begin();
    access(1'b1, 32'h0000_2008, 32'hAAAA_0001);
    snoop(1'b0, 32'h0000_2030);
    expect_abort("R3 R6", 2'd0);
    do_begin();
    run_commit(1'b0, '0);
    check("R8", "writes after abort", got_n, 0);
  endtask

  task automatic t_forward_and_drain();
    do_begin();
    access(1'b1, 32'h0000_3000, 32'h1111_0000);
    snoop(1'b0, 32'h0000_3040);
    expect_running("R6");
    snoop(1'b1, 32'h0000_2FFC);
    expect_running("R6");
    load_probe(32'h0000_3000, 1'b1, 32'h1111_0000);
    load_probe(32'h0000_3004, 1'b0, '0);
    access(1'b1, 32'h0000_3000, 32'h2222_0000);
    access(1'b1, 32'h0000_3010, 32'h3333_0000);
    load_probe(32'h0000_3000, 1'b1, 32'h2222_0000);
    run_commit(1'b0, '0);
    check("R9", "word count", got_n, 2);
    check("R9", "addr0", got_a[0], 32'h0000_3000);
    check("R9", "data0 overwritten", got_d[0], 32'h2222_0000);
    check("R9", "addr1", got_a[1], 32'h0000_3010);
    check("R9", "data1", got_d[1], 32'h3333_0000);
  endtask

  task automatic t_same_cycle();
    do_begin();
    core_req_valid = 1'b1; core_req_write = 1'b1;
    core_req_addr = 32'h0000_4000; core_req_wdata = 32'h4444_0000;
    snp_valid = 1'b1; snp_write = 1'b1; snp_addr = 32'h0000_4000;
    @(negedge clk);
    core_req_valid = 1'b0; snp_valid = 1'b0;
    expect_running("R11");
    snoop(1'b1, 32'h0000_4000);
    expect_abort("R11 R5", 2'd1);
  endtask

  task automatic t_capacity();
    do_begin();
    for (int i = 0; i < 8; i++) access(1'b0, 32'h0000_5000 + 32'(i) * 32'h40, '0);
    expect_running("R7");
    access(1'b0, 32'h0000_5000, '0);
    access(1'b0, 32'h0000_5010, '0);
    expect_running("R2 R7");
    access(1'b0, 32'h0000_5200, '0);
    expect_abort("R7", 2'd2);
    do_begin();
    for (int i = 0; i < 8; i++)
      access(1'b1, 32'h0000_7000 + 32'(i) * 32'h40, 32'(i));
    access(1'b1, 32'h0000_7004, 32'h77);
    expect_running("R2 R7");
    access(1'b1, 32'h0000_7200, 32'h99);
    expect_abort("R7", 2'd2);
    do_begin();
    run_commit(1'b0, '0);
    check("R8", "capacity abort discards", got_n, 0);
  endtask

  task automatic t_order();
    do_begin();
    access(1'b1, 32'h0000_6040, 32'h0000_00A1);
    access(1'b1, 32'h0000_6000, 32'h0000_00B2);
    access(1'b1, 32'h0000_6044, 32'h0000_00C3);
    run_commit(1'b1, 32'h0000_6000);
    check("R9", "word count", got_n, 3);
    check("R9", "first line addr0", got_a[0], 32'h0000_6040);
    check("R9", "first line data0", got_d[0], 32'h0000_00A1);
    check("R9", "first line addr1", got_a[1], 32'h0000_6044);
    check("R9", "first line data1", got_d[1], 32'h0000_00C3);
    check("R9", "second line addr", got_a[2], 32'h0000_6000);
    check("R9", "second line data", got_d[2], 32'h0000_00B2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_set();
    t_write_set_read_conflict();
    t_forward_and_drain();
    t_same_cycle();
    t_capacity();
    t_order();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule